// File: doc/BRIEF.md
# Command-Driven Addressable LED Strip Driver

This block drives a short chain of addressable RGB LEDs over a single-wire data line. It takes five-byte command frames on a byte stream with a valid/ready handshake. It keeps a colour for each LED in a small internal memory. A store command places one LED's colour in that memory and leaves the wire untouched. A show command commits the whole memory to the strip in a single burst.

Each bit on the wire is a high pulse followed by a low pulse. Both widths are counted in clock cycles, and a one bit uses a longer high pulse than a zero bit. After the last bit the wire stays low for a latch interval, and the LEDs take up their new colours during that interval. A busy flag covers the burst and the latch interval. A sticky error flag records any command that was dropped.

The transmit engine is a four-state machine:
- `TX_IDLE`: the wire is low. The machine goes to `TX_HIGH` on a show command.
- `TX_HIGH`: the wire is high. The machine goes to `TX_LOW` once the high width of the current bit has elapsed.
- `TX_LOW`: the wire is low. Once the low width of the bit has elapsed, the machine returns to `TX_HIGH` for the next bit. After the final bit it goes to `TX_LATCH` instead.
- `TX_LATCH`: the wire is low. The machine returns to `TX_IDLE` after the latch interval.

Top module: `ledstrip_cmd_driver`

## Requirements
- R1: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Five accepted bytes form a frame, in this order: opcode, red, green, blue, LED index. Idle gaps between bytes are allowed. No command takes effect before its fifth byte.
- R2: Opcode 0x63 (ASCII 'c') with an index below `NUM_LEDS` writes {green, red, blue} into that LED's slot. `led_out` stays low and `busy` stays low.
- R3: Opcode 0x74 (ASCII 't') sends the slots of LED 0 up to LED `NUM_LEDS`-1 in that order. Each slot is sent as 24 bits: green, then red, then blue, each byte most significant bit first. The colour and index bytes of this frame are ignored.
- R4: A one bit is `T1H` cycles high then `T1L` cycles low. A zero bit is `T0H` cycles high then `T0L` cycles low. The defaults are 140, 120, 70 and 160 cycles, which give 700/600/350/800 ns at 200 MHz.
- R5: After the low part of the last bit, `led_out` stays low for another `TRST` cycles (default 10000). `busy` is high from the first bit until that interval ends. `led_out` is never high while `busy` is low.
- R6: A store with an index of `NUM_LEDS` or more, or any opcode other than 0x63 and 0x74, is dropped and leaves the memory unchanged. It sets `err`, and `err` stays set until reset.
- R7: `in_ready` is low while `busy` is high, so no byte is taken during a transfer.
- R8: After reset, `led_out`, `busy` and `err` are low, `in_ready` is high, and every colour slot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pulse widths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Block can accept a byte |
| led_out | output | 1 | Single-wire data line to the strip |
| busy | output | 1 | Transfer or latch interval in progress |
| err | output | 1 | Sticky flag for dropped commands |

## Verification
The assertions assume that frames stay aligned to five-byte boundaries from reset, so a byte is never taken as the wrong field. The bench keeps to this by sending only whole frames and issuing a reset before every new scenario. The assertions also assume that the sender honours `in_ready` and holds its byte stable until the byte is accepted. The bench driver waits for `in_ready` before each byte and releases `in_valid` only after the accepting edge, including when a show is commanded back to back with other frames. The pulse and latch checks assume the timing parameters are nonzero, so the bench uses scaled-down but nonzero widths to keep transfers short.

// File: rtl/ledstrip_pkg.sv
package ledstrip_pkg;

    localparam logic [7:0] OP_STORE = 8'h63;
    localparam logic [7:0] OP_SHOW  = 8'h74;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HIGH,
        TX_LOW,
        TX_LATCH
    } tx_state_t;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
        logic [7:0] idx;
    } cmd_frame_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ledstrip_rx.sv
module ledstrip_rx
    import ledstrip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       hold,
    output logic       in_ready,
    output logic       frame_valid,
    output cmd_frame_t frame
);

    logic [2:0]  byte_cnt;
    logic [39:0] shreg;
    logic        done_q;
    logic        accept;

    assign in_ready    = !hold && !done_q;
    assign accept      = in_valid && in_ready;
    assign frame_valid = done_q;
    assign frame       = cmd_frame_t'(shreg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            shreg    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= accept && (byte_cnt == 3'd4);
            if (accept) begin
                shreg    <= {shreg[31:0], in_data};
                byte_cnt <= (byte_cnt == 3'd4) ? 3'd0 : byte_cnt + 3'd1;
            end
        end
    end

    // R7: a byte is never taken while the transmitter is active
    a_r7_no_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !in_ready);

endmodule

// File: rtl/ledstrip_mem.sv
module ledstrip_mem #(
    parameter int NUM_LEDS = 8,
    parameter int AW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [23:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [23:0]   rd_data
);

    logic [23:0] slots [NUM_LEDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LEDS; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/ledstrip_tx.sv
module ledstrip_tx
    import ledstrip_pkg::*;
#(
    parameter int NUM_LEDS = 8,
    parameter int AW       = 3,
    parameter int T1H      = 140,
    parameter int T1L      = 120,
    parameter int T0H      = 70,
    parameter int T0L      = 160,
    parameter int TRST     = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] rd_addr,
    input  logic [23:0]   rd_data,
    output logic          led_out,
    output logic          busy
);

    localparam int TMAX = max_of(max_of(max_of(T1H, T1L), max_of(T0H, T0L)), TRST);
    localparam int CW   = $clog2(TMAX + 1) + 1;

    tx_state_t     state_q, state_d;
    logic [AW-1:0] led_q, led_d;
    logic [4:0]    bit_q, bit_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cur_bit, last_bit;
    int            hi_lim, lo_lim;

    assign rd_addr  = led_q;
    assign cur_bit  = rd_data[bit_q];
    assign last_bit = (bit_q == 5'd0) && (led_q == AW'(NUM_LEDS - 1));
    assign hi_lim   = cur_bit ? T1H : T0H;
    assign lo_lim   = cur_bit ? T1L : T0L;

    always_comb begin
        state_d = state_q;
        led_d   = led_q;
        bit_d   = bit_q;
        cnt_d   = cnt_q + CW'(1);
        unique case (state_q)
            TX_IDLE: begin
                cnt_d = '0;
                if (start) state_d = TX_HIGH;
            end
            TX_HIGH: begin
                if (cnt_q == CW'(hi_lim - 1)) begin
                    state_d = TX_LOW;
                    cnt_d   = '0;
                end
            end
            TX_LOW: begin
                if (cnt_q == CW'(lo_lim - 1)) begin
                    cnt_d = '0;
                    if (last_bit) begin
                        state_d = TX_LATCH;
                        led_d   = '0;
                        bit_d   = 5'd23;
                    end else begin
                        state_d = TX_HIGH;
                        if (bit_q == 5'd0) begin
                            led_d = led_q + AW'(1);
                            bit_d = 5'd23;
                        end else begin
                            bit_d = bit_q - 5'd1;
                        end
                    end
                end
            end
            TX_LATCH: begin
                if (cnt_q == CW'(TRST - 1)) begin
                    state_d = TX_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            led_q   <= '0;
            bit_q   <= 5'd23;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            led_q   <= led_d;
            bit_q   <= bit_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        led_out = (state_q == TX_HIGH);
        busy    = (state_q != TX_IDLE);
    end

    // Checker counters for the pulse-width properties
    logic [CW-1:0] hi_len;
    logic [CW:0]   low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len  <= '0;
            low_len <= '0;
        end else begin
            hi_len  <= led_out ? hi_len + CW'(1) : '0;
            low_len <= (busy && !led_out) ? low_len + (CW+1)'(1) : '0;
        end
    end

    // R4: every high pulse is exactly one of the two legal widths
    a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_out) |-> (hi_len == CW'(T1H) || hi_len == CW'(T0H)));

    // R5: busy ends only after the full latch interval of low line
    a_r5_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (low_len >= (CW+1)'(TRST)));

    // R5: the line is never driven high outside a transfer
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !led_out);

endmodule

// File: rtl/ledstrip_cmd_driver.sv
module ledstrip_cmd_driver
    import ledstrip_pkg::*;
#(
    parameter int NUM_LEDS = 8,
    parameter int T1H      = 140,
    parameter int T1L      = 120,
    parameter int T0H      = 70,
    parameter int T0L      = 160,
    parameter int TRST     = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       led_out,
    output logic       busy,
    output logic       err
);

    localparam int AW = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;

    cmd_frame_t    frame;
    logic          frame_valid;
    logic          is_store, is_show, idx_ok;
    logic          wr_en, start, drop;
    logic [AW-1:0] rd_addr;
    logic [23:0]   rd_data;

    ledstrip_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .hold        (busy),
        .in_ready    (in_ready),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    assign is_store = (frame.op == OP_STORE);
    assign is_show  = (frame.op == OP_SHOW);
    assign idx_ok   = (32'(frame.idx) < NUM_LEDS);
    assign wr_en    = frame_valid && is_store && idx_ok;
    assign start    = frame_valid && is_show;
    assign drop     = frame_valid && !(is_show || (is_store && idx_ok));

    ledstrip_mem #(
        .NUM_LEDS (NUM_LEDS),
        .AW       (AW)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (frame.idx[AW-1:0]),
        .wr_data ({frame.green, frame.red, frame.blue}),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ledstrip_tx #(
        .NUM_LEDS (NUM_LEDS),
        .AW       (AW),
        .T1H      (T1H),
        .T1L      (T1L),
        .T0H      (T0H),
        .T0L      (T0L),
        .TRST     (TRST)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .led_out (led_out),
        .busy    (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= 1'b0;
        else if (drop) err <= 1'b1;
    end

    // R6: the error flag never clears without reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R2: a store never starts a transfer
    a_r2_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && is_store) |=> !busy);

    // R7: the colour memory is never written during a transfer
    a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);

endmodule

// File: tb/ledstrip_cmd_driver_tb.sv
module ledstrip_cmd_driver_tb;

    localparam int NL   = 4;
    localparam int T1H  = 14;
    localparam int T1L  = 12;
    localparam int T0H  = 7;
    localparam int T0L  = 16;
    localparam int TRST = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, led_out, busy, err;

    int checks = 0;
    int errors = 0;

    logic [23:0] exp_mem [NL];
    bit          exp_q [$];

    always #4 clk = ~clk;

    ledstrip_cmd_driver #(
        .NUM_LEDS (NL), .T1H (T1H), .T1L (T1L),
        .T0H (T0H), .T0L (T0L), .TRST (TRST)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_ready (in_ready), .led_out (led_out), .busy (busy), .err (err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) exp_mem[i] = '0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hxx;
    endtask

    task automatic send_frame(input logic [7:0] op, input logic [7:0] r,
                              input logic [7:0] g, input logic [7:0] b,
                              input logic [7:0] idx, input int gap);
        send_byte(op, gap);
        send_byte(r, gap);
        send_byte(g, gap);
        send_byte(b, gap);
        send_byte(idx, gap);
    endtask

    // Store: updates the model only for a legal index
    task automatic store(input logic [7:0] r, input logic [7:0] g,
                         input logic [7:0] b, input logic [7:0] idx, input int gap);
        send_frame(8'h63, r, g, b, idx, gap);
        if (idx < NL) exp_mem[idx] = {g, r, b};
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2", "busy after store", busy, 0);
        chk(led_out == 1'b0, "R2", "line after store", led_out, 0);
    endtask

    // Show: pushes the expected bit stream, then waits for completion
    task automatic show(input logic [7:0] r, input logic [7:0] g,
                        input logic [7:0] b, input logic [7:0] idx);
        for (int l = 0; l < NL; l++)
            for (int k = 23; k >= 0; k--) exp_q.push_back(exp_mem[l][k]);
        send_frame(8'h74, r, g, b, idx, 0);
        while (!busy) @(negedge clk);
        chk(in_ready == 1'b0, "R7", "in_ready while busy", in_ready, 0);
        repeat (T1H) @(negedge clk);
        chk(in_ready == 1'b0, "R7", "in_ready mid transfer", in_ready, 0);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "bits left unsent", exp_q.size(), 0);
        chk(led_out == 1'b0, "R5", "line after latch", led_out, 0);
        chk(in_ready == 1'b1, "R7", "in_ready after transfer", in_ready, 1);
    endtask

    // Monitor: decodes pulses on the line and compares against the queue
    initial begin
        int hi_cnt, lo_cnt;
        bit prev_led, prev_busy, have_prev, prev_bit, got;
        hi_cnt = 0; lo_cnt = 0;
        prev_led = 0; prev_busy = 0; have_prev = 0; prev_bit = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_led = 0; prev_busy = 0; have_prev = 0;
                hi_cnt = 0; lo_cnt = 0;
                continue;
            end
            if (led_out && !busy)
                chk(1'b0, "R5", "line high while idle", 1, 0);
            if (led_out) begin
                if (!prev_led) begin
                    if (have_prev)
                        chk(lo_cnt == (prev_bit ? T1L : T0L), "R4", "low width",
                            lo_cnt, prev_bit ? T1L : T0L);
                    hi_cnt = 0;
                end
                hi_cnt++;
            end else if (busy) begin
                if (prev_led) begin
                    got = (hi_cnt == T1H);
                    chk(hi_cnt == T1H || hi_cnt == T0H, "R4", "high width",
                        hi_cnt, got ? T1H : T0H);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3", "unexpected bit", got, 0);
                    end else begin
                        bit e;
                        e = exp_q.pop_front();
                        chk(got == e, "R3", "bit value", got, e);
                    end
                    prev_bit = got;
                    have_prev = 1;
                    lo_cnt = 0;
                end
                lo_cnt++;
            end
            if (!busy && prev_busy) begin
                chk(lo_cnt == (prev_bit ? T1L : T0L) + TRST, "R5", "latch low time",
                    lo_cnt, (prev_bit ? T1L : T0L) + TRST);
                have_prev = 0;
            end
            prev_led  = led_out;
            prev_busy = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R8: reset state
        chk(led_out == 1'b0, "R8", "led_out after reset", led_out, 0);
        chk(busy == 1'b0, "R8", "busy after reset", busy, 0);
        chk(err == 1'b0, "R8", "err after reset", err, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
        // R8: memory zero after reset, seen as an all-zero stream
        show(8'h00, 8'h00, 8'h00, 8'h00);

        // R2/R1: stores with and without idle gaps, distinct bytes check GRB order
        store(8'hA5, 8'h3C, 8'h81, 8'd0, 0);
        store(8'h01, 8'h80, 8'hFF, 8'd3, 2);
        store(8'h5A, 8'hC3, 8'h18, 8'd1, 1);
        chk(err == 1'b0, "R2", "err after legal stores", err, 0);

        // R1: four bytes of a show do nothing until the fifth arrives
        send_byte(8'h74, 0);
        send_byte(8'h11, 0);
        send_byte(8'h22, 0);
        send_byte(8'h33, 0);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy before fifth byte", busy, 0);
        for (int l = 0; l < NL; l++)
            for (int k = 23; k >= 0; k--) exp_q.push_back(exp_mem[l][k]);
        send_byte(8'h02, 0);
        while (busy == 1'b0) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "frame executed after fifth byte", exp_q.size(), 0);

        // R3: colour and index bytes of a show are ignored
        show(8'h12, 8'h34, 8'h56, 8'h02);

        // R6: out-of-range index dropped, memory unchanged, err sticky
        do_reset();
        store(8'hF0, 8'h0F, 8'hAA, 8'd0, 0);
        send_frame(8'h63, 8'h55, 8'h55, 8'h55, 8'(NL), 0);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R6", "err after bad index", err, 1);
        send_frame(8'h63, 8'h77, 8'h77, 8'h77, 8'd200, 0);
        store(8'h00, 8'h42, 8'h00, 8'(NL - 1), 0);
        chk(err == 1'b1, "R6", "err still set", err, 1);
        show(8'h00, 8'h00, 8'h00, 8'h00);
        chk(err == 1'b1, "R6", "err after show", err, 1);

        // R6: unknown opcode dropped
        do_reset();
        chk(err == 1'b0, "R8", "err cleared by reset", err, 0);
        send_frame(8'h78, 8'h99, 8'h99, 8'h99, 8'd1, 0);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R6", "err after unknown opcode", err, 1);
        chk(busy == 1'b0, "R6", "no transfer from unknown opcode", busy, 0);
        show(8'h00, 8'h00, 8'h00, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule